// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers characters from a serial line and hands each one to the surrounding logic as a single-cycle strobe. The strobe comes with the character and two error flags. It reads the same 16-bit configuration word that the companion transmitter uses. From that word it takes:

- the character length (7, 8 or 9 bits),
- the parity rule (none, even or odd),
- the timing mode,
- the sampling edge of the serial clock,
- whether the input is looped back from the local transmitter output.

There are two timing modes. In asynchronous mode, a baud tick at sixteen times the bit rate oversamples the line. A falling edge on the idle-high line starts a frame, the start bit is confirmed at its centre, and every later bit is sampled at its centre. In synchronous mode the block is always the clocked (slave) side. An external serial clock and the data pass through two-flop synchronisers, and one sample is taken on each selected edge of that clock.

Top module: `serial_frame_rx`

## Requirements
- R1: While configuration bit 0 (enable) is 0, the frame state and the bit timer are held cleared and `rx_valid` stays low. After enable returns to 1, the next complete frame is received correctly, even if a frame was cut off by the disable.
- R2: Configuration bits [3:2] give the character length: 0 means 7 bits, 1 means 8 bits, 2 means 9 bits. Data bits arrive LSB first. The character is right-aligned in `rx_data`, unused upper bits read 0, and the ninth bit appears in `rx_data[8]`.
- R3: Configuration bits [5:4] give the parity rule: 0 means no parity bit, 2 means even, 3 means odd. When a parity rule is selected, a single parity bit follows the data. `rx_par_err` is 1 when the count of ones over data and parity is odd under the even rule, or even under the odd rule. Without a parity rule, `rx_par_err` is 0.
- R4: Exactly one stop bit is sampled, whatever the value of configuration bit 6 (the transmitter's two-stop setting). A stop bit sampled low sets `rx_frm_err` for that character, and a frame may start straight after a single stop bit.
- R5: Configuration bit 11 selects the timing mode: 0 is asynchronous, 1 is synchronous.
  - In asynchronous mode, bit timing counts `baud_tick` pulses, 16 per bit. The start bit is sampled 8 ticks after the falling edge is seen.
  - A start bit that reads high at that point is dropped and produces no character.
  - In synchronous mode, activity on the serial line alone, without serial clock edges, delivers nothing.
- R6: In synchronous mode, configuration bit 12 selects the sampling edge of `sclk_pin`: 0 samples on the falling edge, 1 samples on the rising edge. Data that changes on the other edge is never taken. Each sample is one frame bit: start (low), data, optional parity, stop.
- R7: When configuration bit 15 is 1, the receiver takes its input from `txd_loop` and ignores `rxd_pin`. When bit 15 is 0, activity on `txd_loop` has no effect.
- R8: Each character produces exactly one `rx_valid` pulse, one cycle long. `rx_data` and both error flags are registered with it and hold until the next character.
  - Asynchronous mode: the pulse is registered on the clock edge that takes the tick at the centre of the stop bit.
  - Synchronous mode: the pulse is registered on the third clock edge after the final active serial-clock edge appears on the pin.
- R9: Synchronous reset leaves `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Shared configuration word (enable, length, parity, mode, edge, loopback) |
| baud_tick | input | 1 | One-cycle pulse at 16 times the asynchronous bit rate |
| rxd_pin | input | 1 | External serial data input |
| sclk_pin | input | 1 | External serial clock for synchronous mode |
| txd_loop | input | 1 | Local transmitter output, used as input in loopback |
| rx_valid | output | 1 | One-cycle strobe per received character |
| rx_data | output | 9 | Received character, right-aligned |
| rx_par_err | output | 1 | Parity mismatch for the current character |
| rx_frm_err | output | 1 | Stop bit read low for the current character |

## Verification
The bench holds `baud_tick` high on every cycle, so each asynchronous bit lasts 16 clocks. A character is then due exactly 11 + 16·F cycles after the start bit is driven, where F counts the start, data and parity bits. Two of those cycles are the synchroniser, one is the edge register, and the first sample comes 8 ticks into the start bit.

In synchronous mode the character is due three cycles after the last active serial-clock edge is driven: two synchroniser stages, then the output register.

The bench records the cycle counter at each drive and again on each `rx_valid` pulse, sampling at the falling clock edge. It compares that latency to the exact figure. It also counts the pulses, which catches missing or duplicated characters.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CFG_W  = 16;
  localparam int DATA_W = 9;

  // positions shared with the transmitter that decodes the same word
  localparam int F_EN    = 0;
  localparam int F_LEN   = 2;
  localparam int F_PAR   = 4;
  localparam int F_SYNC  = 11;
  localparam int F_EDGE  = 12;
  localparam int F_LOOP  = 15;
  // bits read by the receiver; the rest belong to the transmitter
  localparam logic [CFG_W-1:0] RX_USED_MASK = 16'h983D;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srx_async_timer.sv
module srx_async_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  input  logic line,
  input  logic fsm_idle,
  input  logic frame_end,
  output logic stb
);
  localparam int              CW  = $clog2(OVS);
  localparam logic [CW-1:0]   MID = CW'(OVS / 2);
  localparam logic [CW-1:0]   TOP = CW'(OVS - 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          run, line_q, fell;

  assign fell  = line_q & ~line;
  assign cnt_n = (cnt == TOP) ? '0 : cnt + 1'b1;
  assign stb   = run & tick & (cnt_n == MID);

  always_ff @(posedge clk) begin
    if (clr) begin
      run    <= 1'b0;
      cnt    <= '0;
      line_q <= 1'b1;
    end else begin
      line_q <= line;
      if (!run) begin
        if (fell && fsm_idle) begin
          run <= 1'b1;
          cnt <= '0;
        end
      end else if (frame_end) begin
        run <= 1'b0;
      end else if (tick) begin
        cnt <= cnt_n;
      end
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (clr)
    stb |=> !stb);  // R5
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              stb,
  input  logic              val,
  input  logic [1:0]        len_code,
  input  logic [1:0]        par_code,
  output logic              idle,
  output logic              frame_end,
  output logic              rx_vld,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_pe,
  output logic              rx_fe
);
  rx_state_e         st;
  logic [3:0]        bit_cnt, len_q;
  logic [DATA_W-1:0] shreg;
  logic              par_on_q, odd_q, par_bit;

  assign idle      = (st == ST_IDLE);
  assign frame_end = stb & ((idle & val) | (st == ST_STOP));

  always_ff @(posedge clk) begin
    if (clr) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      len_q    <= 4'd7;
      shreg    <= '0;
      par_on_q <= 1'b0;
      odd_q    <= 1'b0;
      par_bit  <= 1'b0;
      rx_vld   <= 1'b0;
      rx_data  <= '0;
      rx_pe    <= 1'b0;
      rx_fe    <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      if (stb) begin
        unique case (st)
          ST_IDLE: if (!val) begin
            st       <= ST_DATA;
            bit_cnt  <= '0;
            shreg    <= '0;
            len_q    <= char_bits(len_code);
            par_on_q <= par_code[1];
            odd_q    <= par_code[0];
          end
          ST_DATA: begin
            shreg   <= {val, shreg[DATA_W-1:1]};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == len_q - 1'b1) st <= par_on_q ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_bit <= val;
            st      <= ST_STOP;
          end
          ST_STOP: begin
            st      <= ST_IDLE;
            rx_vld  <= 1'b1;
            rx_data <= shreg >> (4'(DATA_W) - len_q);
            rx_pe   <= par_on_q & (^shreg ^ par_bit ^ odd_q);
            rx_fe   <= ~val;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (clr)
    rx_vld |=> !rx_vld);  // R8
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (clr)
    (stb && st == ST_STOP) |=> (rx_vld && (rx_fe == !$past(val))));  // R4
  AST_SEVEN_CLEAR: assert property (@(posedge clk) disable iff (clr)
    (rx_vld && len_q == 4'd7) |-> (rx_data[8:7] == 2'b00));  // R2
  AST_PE_NOPAR: assert property (@(posedge clk) disable iff (clr)
    (rx_vld && !par_on_q) |-> !rx_pe);  // R3
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              baud_tick,
  input  logic              rxd_pin,
  input  logic              sclk_pin,
  input  logic              txd_loop,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  logic en, sync_mode, rise_sel, loop_sel, clr;
  logic unused_cfg;
  assign en         = cfg_word[F_EN];
  assign sync_mode  = cfg_word[F_SYNC];
  assign rise_sel   = cfg_word[F_EDGE];
  assign loop_sel   = cfg_word[F_LOOP];
  assign clr        = rst | ~en;
  assign unused_cfg = ^(cfg_word & ~RX_USED_MASK);

  // loopback is chosen ahead of the synchroniser so both sources share one path
  logic [1:0] sync_q;
  logic       rxd_s, sclk_s, sclk_q;
  srx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_pin, loop_sel ? txd_loop : rxd_pin}),
    .q   (sync_q)
  );
  assign rxd_s  = sync_q[0];
  assign sclk_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  logic sync_edge, sync_stb, async_stb, stb, fsm_idle, frame_end;
  assign sync_edge = rise_sel ? (sclk_s & ~sclk_q) : (~sclk_s & sclk_q);
  assign sync_stb  = sync_mode & en & sync_edge;
  assign stb       = sync_mode ? sync_stb : async_stb;

  srx_async_timer #(.OVS(OVS)) u_timer (
    .clk       (clk),
    .clr       (clr | sync_mode),
    .tick      (baud_tick),
    .line      (rxd_s),
    .fsm_idle  (fsm_idle),
    .frame_end (frame_end),
    .stb       (async_stb)
  );

  srx_frame_fsm u_fsm (
    .clk       (clk),
    .clr       (clr),
    .stb       (stb),
    .val       (rxd_s),
    .len_code  (cfg_word[F_LEN +: 2]),
    .par_code  (cfg_word[F_PAR +: 2]),
    .idle      (fsm_idle),
    .frame_end (frame_end),
    .rx_vld    (rx_valid),
    .rx_data   (rx_data),
    .rx_pe     (rx_par_err),
    .rx_fe     (rx_frm_err)
  );

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({async_stb, sync_stb}));  // R6
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rx_valid);  // R1
endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg = '0;
  logic        tick = 1'b1;
  logic        rxd_pin = 1'b1;
  logic        sclk_pin = 1'b0;
  logic        txd_loop = 1'b1;
  logic        rx_valid, rx_par_err, rx_frm_err;
  logic [8:0]  rx_data;

  serial_frame_rx u_serial_frame_rx (
    .clk(clk), .rst(rst), .cfg_word(cfg), .baud_tick(tick),
    .rxd_pin(rxd_pin), .sclk_pin(sclk_pin), .txd_loop(txd_loop),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int         n_vld = 0;
  int         cap_cyc = 0;
  logic [8:0] cap_d = '0;
  logic       cap_pe = 1'b0, cap_fe = 1'b0;
  always @(negedge clk) if (rx_valid) begin
    n_vld++; cap_cyc = cyc; cap_d = rx_data; cap_pe = rx_par_err; cap_fe = rx_frm_err;
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcfg(bit en, logic [1:0] len, logic [1:0] par,
                                        bit stop2, bit syn, bit rise, bit lp);
    logic [15:0] c = '0;
    c[0] = en; c[3:2] = len; c[5:4] = par; c[6] = stop2;
    c[11] = syn; c[12] = rise; c[15] = lp;
    return c;
  endfunction

  function automatic int nbits(logic [1:0] code);
    return (code == 2'd0) ? 7 : (code == 2'd1) ? 8 : 9;
  endfunction

  task automatic drive(input logic v, input bit via_loop);
    if (via_loop) txd_loop = v; else rxd_pin = v;
  endtask

  task automatic send_async(input int nb, input logic [8:0] d, input bit paron,
                            input bit pb, input bit sb, input bit via_loop, output int t0);
    logic [12:0] fr;
    int nf;
    fr = '0; nf = 1;
    for (int i = 0; i < nb; i++) begin fr[nf] = d[i]; nf++; end
    if (paron) begin fr[nf] = pb; nf++; end
    fr[nf] = sb; nf++;
    @(negedge clk); t0 = cyc;
    for (int k = 0; k < nf; k++) begin
      drive(fr[k], via_loop);
      repeat (16) @(negedge clk);
    end
    drive(1'b1, via_loop);
  endtask

  task automatic send_sync(input int nb, input logic [8:0] d, input bit paron,
                           input bit pb, input bit sb, input bit rise, output int te);
    logic [12:0] fr;
    int nf;
    fr = '0; nf = 1;
    for (int i = 0; i < nb; i++) begin fr[nf] = d[i]; nf++; end
    if (paron) begin fr[nf] = pb; nf++; end
    fr[nf] = sb; nf++;
    for (int k = 0; k < nf; k++) begin
      @(negedge clk);
      rxd_pin = fr[k]; sclk_pin = ~rise;
      repeat (4) @(negedge clk);
      sclk_pin = rise; te = cyc;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    rxd_pin = 1'b1; sclk_pin = ~rise;
  endtask

  // {len code, parity code, data, stop bit, flip parity, expected data, pe, fe, pad}
  localparam logic [31:0] VEC [12] = '{
    {2'd1, 2'd0, 9'h0A5, 1'b1, 1'b0, 9'h0A5, 1'b0, 1'b0, 6'd0},
    {2'd0, 2'd0, 9'h1FF, 1'b1, 1'b0, 9'h07F, 1'b0, 1'b0, 6'd0},
    {2'd2, 2'd0, 9'h1A3, 1'b1, 1'b0, 9'h1A3, 1'b0, 1'b0, 6'd0},
    {2'd1, 2'd2, 9'h03C, 1'b1, 1'b0, 9'h03C, 1'b0, 1'b0, 6'd0},
    {2'd1, 2'd2, 9'h03C, 1'b1, 1'b1, 9'h03C, 1'b1, 1'b0, 6'd0},
    {2'd1, 2'd3, 9'h001, 1'b1, 1'b0, 9'h001, 1'b0, 1'b0, 6'd0},
    {2'd1, 2'd3, 9'h001, 1'b1, 1'b1, 9'h001, 1'b1, 1'b0, 6'd0},
    {2'd2, 2'd3, 9'h155, 1'b1, 1'b0, 9'h155, 1'b0, 1'b0, 6'd0},
    {2'd0, 2'd2, 9'h055, 1'b1, 1'b1, 9'h055, 1'b1, 1'b0, 6'd0},
    {2'd1, 2'd0, 9'h081, 1'b0, 1'b0, 9'h081, 1'b0, 1'b1, 6'd0},
    {2'd1, 2'd2, 9'h00F, 1'b0, 1'b1, 9'h00F, 1'b1, 1'b1, 6'd0},
    {2'd2, 2'd2, 9'h100, 1'b1, 1'b0, 9'h100, 1'b0, 1'b0, 6'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t0, nv, nb;
    logic [8:0] dm;
    bit pb;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(rx_valid == 1'b0 && rx_data == 9'h0 && !rx_par_err && !rx_frm_err,
        "R9 reset outputs", {rx_valid, rx_data, rx_par_err, rx_frm_err}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // table walk, asynchronous mode: R2 R3 R4 R8
    for (int i = 0; i < 12; i++) begin
      cfg = mkcfg(1'b1, VEC[i][31:30], VEC[i][29:28], i[0], 1'b0, 1'b0, 1'b0);
      nb  = nbits(VEC[i][31:30]);
      dm  = VEC[i][27:19] & 9'((1 << nb) - 1);
      pb  = ^dm ^ VEC[i][28] ^ VEC[i][17];
      repeat (4) @(negedge clk);
      nv = n_vld;
      send_async(nb, VEC[i][27:19], VEC[i][29], pb, VEC[i][18], 1'b0, t0);
      repeat (20) @(negedge clk);
      chk(n_vld == nv + 1, "R8 one pulse per char", n_vld - nv, 1);
      chk(cap_d == VEC[i][16:8], "R2 char data", cap_d, VEC[i][16:8]);
      chk(cap_pe == VEC[i][7], "R3 parity flag", cap_pe, VEC[i][7]);
      chk(cap_fe == VEC[i][6], "R4 framing flag", cap_fe, VEC[i][6]);
      chk(cap_cyc == t0 + 11 + 16 * (1 + nb + VEC[i][29]), "R8 async latency",
          cap_cyc - t0, 11 + 16 * (1 + nb + VEC[i][29]));
    end

    // R1: disabled receiver ignores a full frame
    cfg = mkcfg(1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h0C3, 1'b0, 1'b0, 1'b1, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv, "R1 no char while disabled", n_vld - nv, 0);

    // R1: frame cut off by disable, then a clean frame
    cfg = mkcfg(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rxd_pin = 1'b0; repeat (16) @(negedge clk);
    rxd_pin = 1'b1; repeat (32) @(negedge clk);
    rxd_pin = 1'b0; repeat (16) @(negedge clk);
    cfg[0] = 1'b0; repeat (3) @(negedge clk);
    rxd_pin = 1'b1; repeat (3) @(negedge clk);
    cfg[0] = 1'b1; repeat (5) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h05A, 1'b0, 1'b0, 1'b1, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h05A, "R1 clean frame after re-enable", cap_d, 9'h05A);

    // R5: false start is dropped, next frame still received
    nv = n_vld;
    @(negedge clk); rxd_pin = 1'b0;
    repeat (4) @(negedge clk); rxd_pin = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_vld == nv, "R5 false start dropped", n_vld - nv, 0);
    send_async(8, 9'h0E7, 1'b0, 1'b0, 1'b1, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h0E7, "R5 frame after false start", cap_d, 9'h0E7);

    // R4: two-stop setting, frames back to back with one stop bit
    cfg = mkcfg(1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h012, 1'b0, 1'b0, 1'b1, 1'b0, t0);
    send_async(8, 9'h034, 1'b0, 1'b0, 1'b1, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv + 2, "R4 back-to-back count", n_vld - nv, 2);
    chk(cap_d == 9'h034 && !cap_fe, "R4 second frame single stop", cap_d, 9'h034);

    // R7: loopback source selected, pin ignored
    cfg = mkcfg(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h06D, 1'b0, 1'b0, 1'b1, 1'b1, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h06D, "R7 loopback frame", cap_d, 9'h06D);
    chk(cap_cyc == t0 + 11 + 16 * 9, "R7 loopback latency", cap_cyc - t0, 11 + 16 * 9);
    cfg = mkcfg(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h06D, 1'b0, 1'b0, 1'b1, 1'b1, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv, "R7 loop line ignored when off", n_vld - nv, 0);

    // R5: synchronous mode, line activity without clock edges
    cfg = mkcfg(1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_async(8, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(n_vld == nv, "R5 sync mode needs clock", n_vld - nv, 0);

    // R6: rising-edge sampling
    nv = n_vld;
    send_sync(8, 9'h096, 1'b0, 1'b0, 1'b1, 1'b1, t0);
    repeat (10) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h096, "R6 rising edge data", cap_d, 9'h096);
    chk(cap_cyc == t0 + 3, "R8 sync latency", cap_cyc - t0, 3);

    // R6: falling-edge sampling with even parity and a bad stop bit
    cfg = mkcfg(1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_sync(8, 9'h03A, 1'b1, ^9'h03A, 1'b0, 1'b0, t0);
    repeat (10) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h03A, "R6 falling edge data", cap_d, 9'h03A);
    chk(!cap_pe && cap_fe, "R6 falling edge flags", {cap_pe, cap_fe}, 1);

    // R6: nine-bit odd parity, rising edge
    cfg = mkcfg(1'b1, 2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    nv = n_vld;
    send_sync(9, 9'h1C1, 1'b1, ^9'h1C1, 1'b1, 1'b1, t0);
    repeat (10) @(negedge clk);
    chk(n_vld == nv + 1 && cap_d == 9'h1C1, "R6 nine-bit sync data", cap_d, 9'h1C1);
    chk(cap_pe, "R3 odd parity mismatch in sync", cap_pe, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule